// File: doc/BRIEF.md
# Prioritized Interrupt State Vector

This block gathers the event flags of a serial communication controller and presents them to software as one read-only byte. The byte names the most urgent pending source and can be added straight to the base of a jump table, because each source code is scaled by four. The protocol logic raises an event with a one-cycle set pulse. The register interface retires an event with a per-source clear strobe. Between the two, each event is held in a sticky pending flag.

A single interrupt request line is raised while any flag is pending. Software can gate that line with a global enable. While the controller is told to ignore the current message, the vector reads zero and the request line stays low. The pending flags are not lost in that state, and they show again once the ignore state is released.

Top module: `intr_state_vector`

## Requirements
- R1: A set pulse on a source makes its pending flag sticky. The flag stays set after the pulse ends, and from the cycle after the pulse the vector reflects the source.
- R2: The vector is the 4-bit source code placed in bits 5:2, with bits 7:6 and 1:0 reading zero. Set input bit k (k = 0..7) maps to source code k+1: 1 end of frame received, 2 response byte received, 3 receive data full, 4 transmit data empty, 5 arbitration lost, 6 CRC error, 7 bad symbol, 8 wakeup. The vector values therefore run from 0x04 to 0x20.
- R3: When several flags are pending, the vector shows the source with the highest code.
- R4: With no flag pending, the vector reads 0x00.
- R5: A clear strobe drops that source's flag at the next clock edge. From the following cycle the vector shows the next highest pending source, or 0x00 if none remains.
- R6: A set pulse and a clear strobe for the same source in the same cycle leave the flag set.
- R7: The request line is high exactly when at least one flag is pending, the enable is 1 and ignore is 0. An enable of 0 forces the request low and leaves the vector unchanged.
- R8: While ignore is 1, the vector reads 0x00 and the request is low. Flags keep their state and still accept set pulses. The pending sources reappear when ignore returns to 0.
- R9: A synchronous active-high reset clears every flag. During and after reset the vector reads 0x00 and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set | input | 8 | One-cycle set pulses; bit k raises source code k+1 |
| evt_clr | input | 8 | Clear strobes; bit k retires source code k+1 |
| irq_enable | input | 1 | Global interrupt enable |
| ignore_msg | input | 1 | Ignore-message mask; hides vector and request |
| state_vec | output | 8 | Jump-table offset of the top pending source |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is driven to a known level from the first clock edge and changes only between edges. The stability property also assumes that the vector can change only through set, clear, reset or a change of ignore. The enable input is not covered by that assumption, because it leaves the vector alone. The stimulus meets these assumptions by driving all inputs on the falling edge, holding reset from time zero, and changing each input only through a task that places a full set of values at once. The sequences walk each source alone, fill all sources and clear them from the top down, collide a set with a clear, and toggle the enable and the ignore mask while flags are pending.

// File: rtl/isv_pkg.sv
package isv_pkg;
    localparam int NUM_SRC = 8;
    localparam int CODE_W  = $clog2(NUM_SRC + 1);
    localparam int VEC_W   = 8;
    localparam int SHIFT   = 2;

    typedef logic [NUM_SRC-1:0] src_mask_t;
    typedef logic [CODE_W-1:0]  src_code_t;
    typedef logic [VEC_W-1:0]   vec_t;

    typedef struct packed {
        src_code_t code;
        logic      any;
    } top_src_t;

    function automatic vec_t code_to_offset(src_code_t c);
        return vec_t'(c) << SHIFT;
    endfunction
endpackage

// File: rtl/isv_pending.sv
module isv_pending
    import isv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t set_i,
    input  src_mask_t clr_i,
    output src_mask_t pend_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (clr_i[i])
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/isv_prio.sv
module isv_prio
    import isv_pkg::*;
(
    input  src_mask_t pend_i,
    output top_src_t  top_o
);
    always_comb begin
        top_o.code = '0;
        top_o.any  = |pend_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i])
                top_o.code = src_code_t'(i + 1);
        end
    end
endmodule

// File: rtl/isv_gate.sv
module isv_gate
    import isv_pkg::*;
(
    input  top_src_t top_i,
    input  logic     enable_i,
    input  logic     ignore_i,
    output vec_t     vec_o,
    output logic     req_o
);
    always_comb begin
        vec_o = ignore_i ? '0 : code_to_offset(top_i.code);
        req_o = top_i.any & enable_i & ~ignore_i;
    end
endmodule

// File: rtl/intr_state_vector.sv
module intr_state_vector
    import isv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] evt_set,
    input  logic [7:0] evt_clr,
    input  logic       irq_enable,
    input  logic       ignore_msg,
    output logic [7:0] state_vec,
    output logic       irq_req
);
    src_mask_t pend;
    top_src_t  top;

    isv_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .pend_o (pend)
    );

    isv_prio u_prio (
        .pend_i (pend),
        .top_o  (top)
    );

    isv_gate u_gate (
        .top_i    (top),
        .enable_i (irq_enable),
        .ignore_i (ignore_msg),
        .vec_o    (state_vec),
        .req_o    (irq_req)
    );
endmodule

// File: rtl/intr_state_vector_chk.sv
module intr_state_vector_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] evt_set,
    input logic [7:0] evt_clr,
    input logic       irq_enable,
    input logic       ignore_msg,
    input logic [7:0] state_vec,
    input logic       irq_req
);
    // R2: offset format and range
    p_vec_format_r2: assert property (@(posedge clk) disable iff (rst)
        (state_vec[1:0] == 2'b00) && (state_vec[7:6] == 2'b00) && (state_vec[5:2] <= 4'd8));

    // R1: a set pulse is visible on the next cycle unless masked
    p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> (ignore_msg || state_vec != 8'h00));

    // R7: request only when enabled and not ignoring
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_enable && !ignore_msg));

    // R7: with gating open, request tracks a nonzero vector
    p_irq_vec_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_enable && !ignore_msg) |-> (irq_req == (state_vec != 8'h00)));

    // R8: ignore hides the vector
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        ignore_msg |-> (state_vec == 8'h00 && !irq_req));

    // R9: reset empties the block
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (state_vec == 8'h00 && !irq_req));

    // R5: without set or clear the vector holds while ignore holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_set == 8'h00 && evt_clr == 8'h00) |=> (!$stable(ignore_msg) || $stable(state_vec)));
endmodule

bind intr_state_vector intr_state_vector_chk u_chk (.*);

// File: tb/sim_intr_state_vector.sv
`timescale 1ns/1ps
module sim_intr_state_vector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_set = '0;
    logic [7:0] evt_clr = '0;
    logic       irq_enable = 1'b0;
    logic       ignore_msg = 1'b0;
    logic [7:0] state_vec;
    logic       irq_req;

    typedef struct {
        logic [7:0] vec;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    exp_t       item;
    logic [7:0] model_pend = '0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    intr_state_vector u0 (
        .clk(clk), .rst(rst), .evt_set(evt_set), .evt_clr(evt_clr),
        .irq_enable(irq_enable), .ignore_msg(ignore_msg),
        .state_vec(state_vec), .irq_req(irq_req)
    );

    function automatic logic [7:0] model_vec(logic [7:0] p, logic ig);
        logic [3:0] code = '0;
        for (int i = 0; i < 8; i++) if (p[i]) code = 4'(i + 1);
        return ig ? 8'h00 : {2'b00, code, 2'b00};
    endfunction

    task automatic step(input logic r, input logic [7:0] s, input logic [7:0] c,
                        input logic en, input logic ig, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; evt_set = s; evt_clr = c; irq_enable = en; ignore_msg = ig;
        if (r) model_pend = '0;
        else   model_pend = (model_pend & ~c) | s;
        e.vec = model_vec(model_pend, ig);
        e.irq = (|model_pend) & en & ~ig;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item = sb.pop_front();
            checks++;
            if (state_vec !== item.vec || irq_req !== item.irq) begin
                fails++;
                $display("FAIL %s: vec=%h irq=%b expected vec=%h irq=%b",
                         item.tag, state_vec, irq_req, item.vec, item.irq);
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1, 8'h00, 8'h00, 1, 0, "R9");
        step(1, 8'h00, 8'h00, 1, 0, "R9");
        step(0, 8'h00, 8'h00, 1, 0, "R4");
        // R2 / R1 / R5: each source alone
        for (int k = 0; k < 8; k++) begin
            step(0, 8'(1 << k), 8'h00, 1, 0, "R2");
            step(0, 8'h00, 8'h00, 1, 0, "R1");
            step(0, 8'h00, 8'(1 << k), 1, 0, "R5");
        end
        // R3: all pending, then clear from the top down
        step(0, 8'hFF, 8'h00, 1, 0, "R3");
        for (int k = 7; k >= 0; k--) step(0, 8'h00, 8'(1 << k), 1, 0, "R5");
        step(0, 8'h14, 8'h00, 1, 0, "R3");
        step(0, 8'h00, 8'h10, 1, 0, "R5");
        step(0, 8'h00, 8'h04, 1, 0, "R4");
        // R6: set and clear collide
        step(0, 8'h80, 8'h80, 1, 0, "R6");
        step(0, 8'h00, 8'h00, 1, 0, "R6");
        // R7: enable off keeps vector, drops request
        step(0, 8'h00, 8'h00, 0, 0, "R7");
        step(0, 8'h02, 8'h00, 0, 0, "R7");
        step(0, 8'h00, 8'h00, 1, 0, "R7");
        // R8: ignore hides, flags survive and accept sets
        step(0, 8'h00, 8'h00, 1, 1, "R8");
        step(0, 8'h01, 8'h80, 1, 1, "R8");
        step(0, 8'h00, 8'h00, 1, 0, "R8");
        step(0, 8'h00, 8'h02, 1, 0, "R5");
        step(0, 8'h00, 8'h01, 1, 0, "R4");
        // R9: reset with flags pending
        step(0, 8'h48, 8'h00, 1, 0, "R3");
        step(1, 8'h00, 8'h00, 1, 0, "R9");
        step(0, 8'h00, 8'h00, 1, 0, "R9");
        step(0, 8'h00, 8'h00, 1, 0, "R4");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule